// File: doc/BRIEF.md
# Multi-Cycle Processor Sequencer

This block is the control unit of a small 16-bit processor that takes several clock cycles per instruction. It is a Moore state machine. Every instruction goes through one shared fetch state and one shared decode state. In decode the machine branches, on the 3-bit opcode and, for register-type instructions, on the 4-bit function field, into execute states that belong to that instruction alone. After the last execute state it returns to fetch.

All control outputs are decoded from the current state only. The datapath registers, the ALU and the memory live outside this block. The datapath is expected to behave as follows:
- It feeds the opcode and function fields straight from its instruction register.
- It feeds a zero flag from the ALU result of the current cycle.
- It latches the ALU result into an ALU-out register every cycle.
- It clears its program counter on the same reset that puts this block into fetch.

Top module: `mc_ctrl`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, the block is in fetch. Fetch drives pc_ld=1, pc_src=0 (ALU result), ir_ld=1, mem_rd=1, addr_src=0 (PC), alu_a_src=0 (PC), alu_b_src=1 (constant one) and alu_op=0 (add). Every other output is 0.
- R2: The cycle after fetch is decode. Decode drives ab_ld=1 and every other output 0.
- R3: Opcode 0 with function 0..4 gives one execute cycle and then fetch. That execute cycle drives alu_a_src=1 (A), alu_b_src=0 (B), alu_op equal to the function code (0 add, 1 sub, 2 and, 3 or, 4 slt), rf_we=1, rf_wsel=0 (rd) and rf_dsel=0 (ALU). Every other output is 0.
- R4: Opcode 0 with function 5..15, and opcode 6, go from decode straight back to fetch.
- R5: Opcode 1 (load) runs three states and then fetch:
  - address: alu_a_src=1, alu_b_src=2 (sign-extended offset), alu_op=0, with no write strobes.
  - read: mem_rd=1, addr_src=1 (ALU-out register), mdr_ld=1.
  - write-back: rf_we=1, rf_wsel=1 (rt), rf_dsel=1 (memory data register).
- R6: Opcode 2 (store) runs the same address state as R5, then a state with mem_wr=1 and addr_src=1, then fetch.
- R7: Opcode 3 (branch if equal) runs a compare state with alu_a_src=1, alu_b_src=0 and alu_op=1 (sub).
  - If zero is 1 at the end of that state, a taken state follows with pc_ld=1, pc_src=0, alu_a_src=0, alu_b_src=2 and alu_op=0, and then fetch.
  - If zero is 0, fetch follows the compare state directly.
- R8: Opcode 4 (add immediate) gives one execute cycle with alu_a_src=1, alu_b_src=2, alu_op=0, rf_we=1, rf_wsel=1 and rf_dsel=0, and then fetch.
- R9: Opcode 5 (jump) gives one cycle with pc_ld=1 and pc_src=1 (zero-extended 13-bit target), and then fetch.
- R10: Opcode 7 (halt) enters a state in which every output is 0 whatever the inputs do. Only reset leaves it.
- R11: mem_rd and mem_wr are never 1 in the same cycle.
- R12: The opcode and function inputs are used only in decode, and zero only in the branch compare state. Changing them in any other cycle does not alter the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 3 | Instruction bits 15:13 from the instruction register |
| funct | input | 4 | Instruction bits 3:0 from the instruction register |
| zero | input | 1 | ALU result equals zero |
| pc_ld | output | 1 | Load program counter |
| pc_src | output | 1 | PC source: 0 ALU result, 1 jump target |
| ir_ld | output | 1 | Load instruction register from memory data |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe (data from B) |
| addr_src | output | 1 | Memory address: 0 PC, 1 ALU-out register |
| alu_a_src | output | 1 | ALU A input: 0 PC, 1 operand A |
| alu_b_src | output | 2 | ALU B input: 0 operand B, 1 constant one, 2 sign-extended offset |
| alu_op | output | 3 | 0 add, 1 sub, 2 and, 3 or, 4 set-less-than |
| rf_we | output | 1 | Register file write enable |
| rf_wsel | output | 1 | Write register: 0 rd, 1 rt |
| rf_dsel | output | 1 | Write data: 0 ALU result, 1 memory data register |
| ab_ld | output | 1 | Latch register-file outputs into A and B |
| mdr_ld | output | 1 | Latch memory data into the memory data register |

## Verification
Fetch is the one state where two separate transfers overlap. The instruction register is captured from a memory read, and the PC is incremented through the ALU in the same cycle. Every instruction run compares that whole output word against the expected value.

The second overlap is between the branch decision and the dispatch inputs. The zero flag is held at each value across every opcode/function pair. The opcode and function are inverted straight after the decode edge, so a design that samples them outside decode, or consults zero outside the compare state, shows a wrong state sequence.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;

    localparam int OP_W  = 3;
    localparam int FN_W  = 4;
    localparam int AOP_W = 3;
    localparam int BSEL_W = 2;

    // opcode values
    localparam logic [OP_W-1:0] OPC_RTYPE = 3'd0;
    localparam logic [OP_W-1:0] OPC_LOAD  = 3'd1;
    localparam logic [OP_W-1:0] OPC_STORE = 3'd2;
    localparam logic [OP_W-1:0] OPC_BREQ  = 3'd3;
    localparam logic [OP_W-1:0] OPC_ADDI  = 3'd4;
    localparam logic [OP_W-1:0] OPC_JUMP  = 3'd5;
    localparam logic [OP_W-1:0] OPC_HALT  = 3'd7;

    // function values of register-type instructions
    localparam logic [FN_W-1:0] FN_ADD = 4'd0;
    localparam logic [FN_W-1:0] FN_SUB = 4'd1;
    localparam logic [FN_W-1:0] FN_AND = 4'd2;
    localparam logic [FN_W-1:0] FN_OR  = 4'd3;
    localparam logic [FN_W-1:0] FN_SLT = 4'd4;

    // ALU operation codes
    localparam logic [AOP_W-1:0] AOP_ADD = 3'd0;
    localparam logic [AOP_W-1:0] AOP_SUB = 3'd1;
    localparam logic [AOP_W-1:0] AOP_AND = 3'd2;
    localparam logic [AOP_W-1:0] AOP_OR  = 3'd3;
    localparam logic [AOP_W-1:0] AOP_SLT = 3'd4;

    // ALU B source values
    localparam logic [BSEL_W-1:0] BSEL_REG = 2'd0;
    localparam logic [BSEL_W-1:0] BSEL_ONE = 2'd1;
    localparam logic [BSEL_W-1:0] BSEL_OFS = 2'd2;

    typedef enum logic [4:0] {
        ST_FETCH,
        ST_DECODE,
        ST_R_ADD,
        ST_R_SUB,
        ST_R_AND,
        ST_R_OR,
        ST_R_SLT,
        ST_LD_ADDR,
        ST_LD_READ,
        ST_LD_WB,
        ST_ST_ADDR,
        ST_ST_WRITE,
        ST_BR_CMP,
        ST_BR_TAKE,
        ST_ADDI,
        ST_JUMP,
        ST_HALT
    } ctl_state_e;

    typedef struct packed {
        logic              pc_ld;
        logic              pc_src;
        logic              ir_ld;
        logic              mem_rd;
        logic              mem_wr;
        logic              addr_src;
        logic              alu_a_src;
        logic [BSEL_W-1:0] alu_b_src;
        logic [AOP_W-1:0]  alu_op;
        logic              rf_we;
        logic              rf_wsel;
        logic              rf_dsel;
        logic              ab_ld;
        logic              mdr_ld;
    } ctl_word_t;

    typedef struct packed {
        ctl_state_e state;
    } seq_reg_t;

endpackage

// File: rtl/mc_dispatch.sv
module mc_dispatch
    import mc_ctrl_pkg::*;
(
    input  ctl_state_e            cur,
    input  logic [OP_W-1:0]       opcode,
    input  logic [FN_W-1:0]       funct,
    input  logic                  zero,
    output ctl_state_e            nxt
);

    ctl_state_e rtype_tgt;
    ctl_state_e dec_tgt;

    always_comb begin
        unique case (funct)
            FN_ADD:  rtype_tgt = ST_R_ADD;
            FN_SUB:  rtype_tgt = ST_R_SUB;
            FN_AND:  rtype_tgt = ST_R_AND;
            FN_OR:   rtype_tgt = ST_R_OR;
            FN_SLT:  rtype_tgt = ST_R_SLT;
            default: rtype_tgt = ST_FETCH;
        endcase
    end

    always_comb begin
        unique case (opcode)
            OPC_RTYPE: dec_tgt = rtype_tgt;
            OPC_LOAD:  dec_tgt = ST_LD_ADDR;
            OPC_STORE: dec_tgt = ST_ST_ADDR;
            OPC_BREQ:  dec_tgt = ST_BR_CMP;
            OPC_ADDI:  dec_tgt = ST_ADDI;
            OPC_JUMP:  dec_tgt = ST_JUMP;
            OPC_HALT:  dec_tgt = ST_HALT;
            default:   dec_tgt = ST_FETCH;
        endcase
    end

    always_comb begin
        unique case (cur)
            ST_FETCH:    nxt = ST_DECODE;
            ST_DECODE:   nxt = dec_tgt;
            ST_LD_ADDR:  nxt = ST_LD_READ;
            ST_LD_READ:  nxt = ST_LD_WB;
            ST_ST_ADDR:  nxt = ST_ST_WRITE;
            ST_BR_CMP:   nxt = zero ? ST_BR_TAKE : ST_FETCH;
            ST_HALT:     nxt = ST_HALT;
            default:     nxt = ST_FETCH;
        endcase
    end

endmodule

// File: rtl/mc_out_decode.sv
module mc_out_decode
    import mc_ctrl_pkg::*;
(
    input  ctl_state_e cur,
    output ctl_word_t  ctl
);

    always_comb begin
        ctl = '0;
        unique case (cur)
            ST_FETCH: begin
                ctl.pc_ld     = 1'b1;
                ctl.ir_ld     = 1'b1;
                ctl.mem_rd    = 1'b1;
                ctl.alu_b_src = BSEL_ONE;
                ctl.alu_op    = AOP_ADD;
            end
            ST_DECODE: begin
                ctl.ab_ld = 1'b1;
            end
            ST_R_ADD, ST_R_SUB, ST_R_AND, ST_R_OR, ST_R_SLT: begin
                ctl.alu_a_src = 1'b1;
                ctl.alu_b_src = BSEL_REG;
                ctl.rf_we     = 1'b1;
                unique case (cur)
                    ST_R_SUB: ctl.alu_op = AOP_SUB;
                    ST_R_AND: ctl.alu_op = AOP_AND;
                    ST_R_OR:  ctl.alu_op = AOP_OR;
                    ST_R_SLT: ctl.alu_op = AOP_SLT;
                    default:  ctl.alu_op = AOP_ADD;
                endcase
            end
            ST_LD_ADDR, ST_ST_ADDR: begin
                ctl.alu_a_src = 1'b1;
                ctl.alu_b_src = BSEL_OFS;
                ctl.alu_op    = AOP_ADD;
            end
            ST_LD_READ: begin
                ctl.mem_rd   = 1'b1;
                ctl.addr_src = 1'b1;
                ctl.mdr_ld   = 1'b1;
            end
            ST_LD_WB: begin
                ctl.rf_we   = 1'b1;
                ctl.rf_wsel = 1'b1;
                ctl.rf_dsel = 1'b1;
            end
            ST_ST_WRITE: begin
                ctl.mem_wr   = 1'b1;
                ctl.addr_src = 1'b1;
            end
            ST_BR_CMP: begin
                ctl.alu_a_src = 1'b1;
                ctl.alu_b_src = BSEL_REG;
                ctl.alu_op    = AOP_SUB;
            end
            ST_BR_TAKE: begin
                ctl.pc_ld     = 1'b1;
                ctl.alu_b_src = BSEL_OFS;
                ctl.alu_op    = AOP_ADD;
            end
            ST_ADDI: begin
                ctl.alu_a_src = 1'b1;
                ctl.alu_b_src = BSEL_OFS;
                ctl.alu_op    = AOP_ADD;
                ctl.rf_we     = 1'b1;
                ctl.rf_wsel   = 1'b1;
            end
            ST_JUMP: begin
                ctl.pc_ld  = 1'b1;
                ctl.pc_src = 1'b1;
            end
            default: ctl = '0;
        endcase
    end

endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl
    import mc_ctrl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] opcode,
    input  logic [3:0] funct,
    input  logic       zero,
    output logic       pc_ld,
    output logic       pc_src,
    output logic       ir_ld,
    output logic       mem_rd,
    output logic       mem_wr,
    output logic       addr_src,
    output logic       alu_a_src,
    output logic [1:0] alu_b_src,
    output logic [2:0] alu_op,
    output logic       rf_we,
    output logic       rf_wsel,
    output logic       rf_dsel,
    output logic       ab_ld,
    output logic       mdr_ld
);

    seq_reg_t   seq_d, seq_q;
    ctl_state_e nxt_state;
    ctl_word_t  ctl;

    mc_dispatch u_dispatch (
        .cur    (seq_q.state),
        .opcode (opcode),
        .funct  (funct),
        .zero   (zero),
        .nxt    (nxt_state)
    );

    mc_out_decode u_decode (
        .cur (seq_q.state),
        .ctl (ctl)
    );

    always_comb begin
        seq_d       = seq_q;
        seq_d.state = nxt_state;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{state: ST_FETCH};
        else        seq_q <= seq_d;
    end

    assign pc_ld     = ctl.pc_ld;
    assign pc_src    = ctl.pc_src;
    assign ir_ld     = ctl.ir_ld;
    assign mem_rd    = ctl.mem_rd;
    assign mem_wr    = ctl.mem_wr;
    assign addr_src  = ctl.addr_src;
    assign alu_a_src = ctl.alu_a_src;
    assign alu_b_src = ctl.alu_b_src;
    assign alu_op    = ctl.alu_op;
    assign rf_we     = ctl.rf_we;
    assign rf_wsel   = ctl.rf_wsel;
    assign rf_dsel   = ctl.rf_dsel;
    assign ab_ld     = ctl.ab_ld;
    assign mdr_ld    = ctl.mdr_ld;

    assert_rdwr_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    assert_fetch_then_decode_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ir_ld |=> ab_ld);

    assert_write_ends_instr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |=> ir_ld);

    assert_store_ends_instr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> ir_ld);

    assert_halt_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == ST_HALT) |=> (seq_q.state == ST_HALT));

    assert_take_needs_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == ST_BR_TAKE) |-> $past(zero));

endmodule

// File: tb/mc_ctrl_tb.sv
module mc_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] opcode = '0;
    logic [3:0] funct = '0;
    logic       zero = 1'b0;
    logic       pc_ld, pc_src, ir_ld, mem_rd, mem_wr, addr_src, alu_a_src;
    logic [1:0] alu_b_src;
    logic [2:0] alu_op;
    logic       rf_we, rf_wsel, rf_dsel, ab_ld, mdr_ld;

    int n_checks = 0;
    int n_fails  = 0;

    always #4 clk = ~clk;

    mc_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .opcode(opcode), .funct(funct), .zero(zero),
        .pc_ld(pc_ld), .pc_src(pc_src), .ir_ld(ir_ld), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .addr_src(addr_src), .alu_a_src(alu_a_src),
        .alu_b_src(alu_b_src), .alu_op(alu_op), .rf_we(rf_we),
        .rf_wsel(rf_wsel), .rf_dsel(rf_dsel), .ab_ld(ab_ld), .mdr_ld(mdr_ld)
    );

    localparam int K_FETCH = 0, K_DEC = 1, K_REXE = 2, K_MADDR = 3, K_LREAD = 4,
                   K_LWB = 5, K_SWR = 6, K_CMP = 7, K_TAKE = 8, K_ADDI = 9,
                   K_JMP = 10, K_IDLE = 11;

    // packing: pc_ld,pc_src,ir_ld,mem_rd,mem_wr,addr_src,a_src,b_src[2],op[3],we,wsel,dsel,ab_ld,mdr_ld
    function automatic logic [16:0] expv(int kind, logic [2:0] fop);
        case (kind)
            K_FETCH: return {1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,2'd1,3'd0,1'b0,1'b0,1'b0,1'b0,1'b0};
            K_DEC:   return 17'b1 << 1;
            K_REXE:  return {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'd0,fop, 1'b1,1'b0,1'b0,1'b0,1'b0};
            K_MADDR: return {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'd2,3'd0,1'b0,1'b0,1'b0,1'b0,1'b0};
            K_LREAD: return {1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,2'd0,3'd0,1'b0,1'b0,1'b0,1'b0,1'b1};
            K_LWB:   return {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,3'd0,1'b1,1'b1,1'b1,1'b0,1'b0};
            K_SWR:   return {1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,2'd0,3'd0,1'b0,1'b0,1'b0,1'b0,1'b0};
            K_CMP:   return {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'd0,3'd1,1'b0,1'b0,1'b0,1'b0,1'b0};
            K_TAKE:  return {1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'd2,3'd0,1'b0,1'b0,1'b0,1'b0,1'b0};
            K_ADDI:  return {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'd2,3'd0,1'b1,1'b1,1'b0,1'b0,1'b0};
            K_JMP:   return {1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,3'd0,1'b0,1'b0,1'b0,1'b0,1'b0};
            default: return '0;
        endcase
    endfunction

    function automatic logic [16:0] actual();
        return {pc_ld,pc_src,ir_ld,mem_rd,mem_wr,addr_src,alu_a_src,alu_b_src,alu_op,
                rf_we,rf_wsel,rf_dsel,ab_ld,mdr_ld};
    endfunction

    task automatic check(int kind, logic [2:0] fop, string req);
        logic [16:0] e;
        e = expv(kind, fop);
        n_checks++;
        if (actual() !== e) begin
            n_fails++;
            $display("FAIL %s op=%0d fn=%0d z=%0d kind=%0d actual=%b expected=%b",
                     req, opcode, funct, zero, kind, actual(), e);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        #1;
        check(K_FETCH, 3'd0, "R1 during reset");
        step();
        step();
        rst_n = 1'b1;
        #1;
        check(K_FETCH, 3'd0, "R1 after reset");
    endtask

    initial begin
        #(8 * 200000);
        n_fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        do_reset();
        for (int op = 0; op < 8; op++) begin
            for (int fn = 0; fn < 16; fn++) begin
                for (int z = 0; z < 2; z++) begin
                    // DUT is in fetch here
                    opcode = 3'(op);
                    funct  = 4'(fn);
                    zero   = z[0];
                    step();
                    check(K_DEC, 3'd0, "R2 decode");
                    step();
                    // R12: scramble dispatch inputs once decode is over
                    opcode = ~3'(op);
                    funct  = ~4'(fn);
                    case (op)
                        0: begin
                            if (fn < 5) begin
                                check(K_REXE, 3'(fn), "R3 rtype exec");
                                step();
                            end
                            check(K_FETCH, 3'd0, fn < 5 ? "R3 back to fetch" : "R4 unused funct");
                        end
                        1: begin
                            check(K_MADDR, 3'd0, "R5 load addr"); step();
                            check(K_LREAD, 3'd0, "R5 load read"); step();
                            check(K_LWB,   3'd0, "R5 load wb");   step();
                            check(K_FETCH, 3'd0, "R5 load done R12");
                        end
                        2: begin
                            check(K_MADDR, 3'd0, "R6 store addr"); step();
                            check(K_SWR,   3'd0, "R6 store write R11"); step();
                            check(K_FETCH, 3'd0, "R6 store done R12");
                        end
                        3: begin
                            check(K_CMP, 3'd0, "R7 compare"); step();
                            if (z == 1) begin
                                check(K_TAKE, 3'd0, "R7 taken"); step();
                            end
                            check(K_FETCH, 3'd0, "R7 branch done");
                        end
                        4: begin
                            check(K_ADDI, 3'd0, "R8 addi"); step();
                            check(K_FETCH, 3'd0, "R8 addi done");
                        end
                        5: begin
                            check(K_JMP, 3'd0, "R9 jump"); step();
                            check(K_FETCH, 3'd0, "R9 jump done");
                        end
                        6: check(K_FETCH, 3'd0, "R4 unused opcode");
                        default: begin
                            for (int k = 0; k < 6; k++) begin
                                check(K_IDLE, 3'd0, "R10 halted");
                                opcode = 3'(k);
                                funct  = 4'(k + fn);
                                zero   = ~zero;
                                step();
                            end
                            check(K_IDLE, 3'd0, "R10 still halted");
                            do_reset();
                        end
                    endcase
                end
            end
        end
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule